// File: doc/BRIEF.md
# Paged Memory Bank Controller

This block sits between an 8-bit CPU and the memories of a terminal-class controller and turns each 16-bit CPU address into a physical address, together with a select telling which memory answers. The lower half of the CPU space (0x0000-0x7FFF) is a 32 KiB view into one of six 32 KiB ROM banks. The range 0xA000-0xBFFF reaches a small fixed RAM. The two 8 KiB windows at 0xC000 and 0xE000 each show one of nine 8 KiB pages of a 72 KiB banked RAM. The range 0x8000-0x9FFF is not served by any memory here.

The ROM bank is chosen by a CPU memory write to 0x8000. The bank number sits in a sparse encoding of three data bits, so some data values do not name any bank. Such a value leaves the bank as it was and sets an error flag that stays up until reset. The RAM pages are chosen by two registers that the CPU writes over its I/O bus. The page of the upper window depends on both registers. Register updates take effect on the clock edge that samples the write strobe. Translation is combinational, so it always uses the register values of the current cycle.

Top module: `paged_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 0, both page registers hold zero and `bank_err` is 0. A read at 0x0000 gives physical address 0, at 0xC000 gives 0x00000 and at 0xE000 gives 0x02000.
- R2: For CPU addresses 0x0000-0x7FFF, `rom_sel` is 1 and `phys_addr` = bank x 0x8000 + address[14:0].
- R3: A memory write to 0x8000 selects a bank from (data AND 0x19): 0x00 gives 0, 0x08 gives 1, 0x10 gives 2, 0x18 gives 3, 0x01 gives 4, 0x11 gives 5. Data bits 7:5, 2 and 1 have no effect. The new bank applies from the cycle after the write.
- R4: A write to 0x8000 whose masked code is 0x09 or 0x19 leaves the bank unchanged and sets `bank_err`, which stays 1 until reset.
- R5: For 0xA000-0xBFFF, `fix_ram_sel` is 1 and `phys_addr` = address[12:0].
- R6: For 0xC000-0xDFFF, `page_ram_sel` is 1. The page is bits 3:2 of the low page register (I/O port 0x1D), and `phys_addr` = page x 0x2000 + address[12:0].
- R7: For 0xE000-0xFFFF, `page_ram_sel` is 1. The page comes from bits 7:6 of port 0x1D: 00 gives page 1, 01 gives page 4 + bit 3 of the auxiliary register (port 0x1E), 10 gives page 6 + bit 2 of port 0x1E, and 11 gives page 8.
- R8: Page registers change only on an I/O write to port 0x1D or 0x1E. I/O writes to other ports, and memory writes to addresses other than 0x8000, change no register.
- R9: For 0x8000-0x9FFF all three selects are 0 and `phys_addr` is 0. At most one select is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| mem_wr | input | 1 | CPU memory write strobe |
| io_wr | input | 1 | CPU I/O write strobe |
| io_port | input | 8 | Low byte of the I/O address |
| phys_addr | output | 18 | Translated physical address |
| rom_sel | output | 1 | ROM bank window is addressed |
| fix_ram_sel | output | 1 | Fixed RAM is addressed |
| page_ram_sel | output | 1 | Banked RAM is addressed |
| bank_err | output | 1 | Sticky error for an unknown ROM bank code |

## Verification
Each of the six legal ROM codes is written first with the ignored data bits clear and then with them set. This separates a correct three-bit decode from one that reads the wrong bits or treats the code as binary. All four upper-window modes are tried under both values of the auxiliary bit that mode uses. This shows whether the wrong auxiliary bit feeds the page. The two illegal codes are written after a non-zero bank is set, so a bank that silently changes becomes visible, and a later reset shows that the error flag clears. A long random phase mixes strobes, ports and addresses around the register locations, and a behavioural model compares every output in every cycle.

// File: rtl/paged_bank_ctrl.sv
module paged_bank_ctrl #(
  parameter logic [15:0] ROM_STROBE_ADDR = 16'h8000,
  parameter logic [7:0]  LO_PAGE_PORT    = 8'h1D,
  parameter logic [7:0]  AUX_PAGE_PORT   = 8'h1E,
  parameter int          PHYS_W          = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [7:0]        io_port,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              rom_sel,
  output logic              fix_ram_sel,
  output logic              page_ram_sel,
  output logic              bank_err
);

  localparam int ROM_OFS_W  = 15;
  localparam int PAGE_OFS_W = 13;

  logic [2:0] rom_bank;
  logic [1:0] lo_sel;
  logic [1:0] hi_mode;
  logic       aux_b3, aux_b2;
  logic       err_q;

  logic       rom_hit, lo_hit, aux_hit;
  logic       code_ok;
  logic [2:0] code_bank;
  logic [3:0] lo_page, hi_page, page;

  assign rom_hit = mem_wr && (cpu_addr == ROM_STROBE_ADDR);
  assign lo_hit  = io_wr && (io_port == LO_PAGE_PORT);
  assign aux_hit = io_wr && (io_port == AUX_PAGE_PORT);

  always_comb begin
    code_ok   = 1'b1;
    code_bank = rom_bank;
    case (cpu_wdata & 8'h19)
      8'h00:   code_bank = 3'd0;
      8'h08:   code_bank = 3'd1;
      8'h10:   code_bank = 3'd2;
      8'h18:   code_bank = 3'd3;
      8'h01:   code_bank = 3'd4;
      8'h11:   code_bank = 3'd5;
      default: code_ok   = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank <= 3'd0;
      lo_sel   <= 2'd0;
      hi_mode  <= 2'd0;
      aux_b3   <= 1'b0;
      aux_b2   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (rom_hit) begin
        if (code_ok) rom_bank <= code_bank;
        else         err_q    <= 1'b1;
      end
      if (lo_hit) begin
        lo_sel  <= cpu_wdata[3:2];
        hi_mode <= cpu_wdata[7:6];
      end
      if (aux_hit) begin
        aux_b3 <= cpu_wdata[3];
        aux_b2 <= cpu_wdata[2];
      end
    end
  end

  assign bank_err = err_q;

  assign lo_page = {2'b00, lo_sel};

  always_comb begin
    case (hi_mode)
      2'b00:   hi_page = 4'd1;
      2'b01:   hi_page = {3'b010, aux_b3};
      2'b10:   hi_page = {3'b011, aux_b2};
      default: hi_page = 4'd8;
    endcase
  end

  assign page = cpu_addr[13] ? hi_page : lo_page;

  assign rom_sel      = ~cpu_addr[15];
  assign fix_ram_sel  = (cpu_addr[15:13] == 3'b101);
  assign page_ram_sel = (cpu_addr[15:14] == 2'b11);

  always_comb begin
    phys_addr = '0;
    if (rom_sel)
      phys_addr = PHYS_W'({rom_bank, cpu_addr[ROM_OFS_W-1:0]});
    else if (fix_ram_sel)
      phys_addr = PHYS_W'(cpu_addr[PAGE_OFS_W-1:0]);
    else if (page_ram_sel)
      phys_addr = PHYS_W'({page, cpu_addr[PAGE_OFS_W-1:0]});
  end

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_err |=> bank_err);

  // R4
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_hit && !code_ok) |=> ($stable(rom_bank) && bank_err));

  // R3
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank < 3'd6);

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, fix_ram_sel, page_ram_sel}));

  // R7
  hi_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_ram_sel && cpu_addr[13]) |->
      (phys_addr[16:13] inside {4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8}));

  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable({lo_sel, hi_mode, aux_b3, aux_b2}));

endmodule

// File: tb/paged_bank_ctrl_tb.sv
module paged_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_wr = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = '0;
  logic [17:0] phys_addr;
  logic        rom_sel, fix_ram_sel, page_ram_sel, bank_err;

  int checks = 0;
  int fails = 0;
  int m_bank, m_lo, m_aux, m_err;

  always #2 clk = ~clk;

  paged_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_wr(mem_wr), .io_wr(io_wr), .io_port(io_port),
    .phys_addr(phys_addr), .rom_sel(rom_sel), .fix_ram_sel(fix_ram_sel),
    .page_ram_sel(page_ram_sel), .bank_err(bank_err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h)", req, act, exp, cpu_addr);
    end
  endtask

  task automatic compare();
    int a, pg, e_phys, e_rom, e_fix, e_pg;
    string tag;
    a = cpu_addr;
    e_rom = 0; e_fix = 0; e_pg = 0; e_phys = 0;
    if (a < 32'h8000) begin
      e_rom = 1; e_phys = m_bank * 32'h8000 + a % 32'h8000; tag = "R2";
    end else if (a < 32'hA000) begin
      tag = "R9";
    end else if (a < 32'hC000) begin
      e_fix = 1; e_phys = a % 32'h2000; tag = "R5";
    end else begin
      e_pg = 1;
      if (a < 32'hE000) begin
        pg = (m_lo >> 2) & 3; tag = "R6";
      end else begin
        case ((m_lo >> 6) & 3)
          0: pg = 1;
          1: pg = 4 + ((m_aux >> 3) & 1);
          2: pg = 6 + ((m_aux >> 2) & 1);
          default: pg = 8;
        endcase
        tag = "R7";
      end
      e_phys = pg * 32'h2000 + a % 32'h2000;
    end
    chk(tag, int'(phys_addr), e_phys);
    chk("R9 rom_sel", int'(rom_sel), e_rom);
    chk("R9 fix_ram_sel", int'(fix_ram_sel), e_fix);
    chk("R9 page_ram_sel", int'(page_ram_sel), e_pg);
    chk("R4 bank_err", int'(bank_err), m_err);
  endtask

  task automatic model_update();
    int code;
    if (mem_wr && cpu_addr == 16'h8000) begin
      code = cpu_wdata & 8'h19;
      case (code)
        8'h00: m_bank = 0;
        8'h08: m_bank = 1;
        8'h10: m_bank = 2;
        8'h18: m_bank = 3;
        8'h01: m_bank = 4;
        8'h11: m_bank = 5;
        default: m_err = 1;
      endcase
    end
    if (io_wr && io_port == 8'h1D) m_lo = cpu_wdata;
    if (io_wr && io_port == 8'h1E) m_aux = cpu_wdata;
  endtask

  task automatic step(logic [15:0] a, logic [7:0] d, logic mw, logic iw, logic [7:0] p);
    cpu_addr = a; cpu_wdata = d; mem_wr = mw; io_wr = iw; io_port = p;
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic rd(logic [15:0] a);
    step(a, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mem_wr = 1'b0; io_wr = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_bank = 0; m_lo = 0; m_aux = 0; m_err = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] codes [6];
    codes = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h01, 8'h11};
    do_reset();
    // R1 reset state
    #1;
    chk("R1 bank_err", int'(bank_err), 0);
    rd(16'h0000); rd(16'hC000); rd(16'hE000);
    rd(16'h7FFF); rd(16'hA123); rd(16'h8000); rd(16'h9FFF);
    // R3 legal codes, clean then with ignored bits set
    for (int i = 0; i < 6; i++) begin
      step(16'h8000, codes[i], 1'b1, 1'b0, 8'h00);
      rd(16'h1234); rd(16'h7FFF);
      step(16'h8000, codes[5 - i] | 8'hE6, 1'b1, 1'b0, 8'h00);
      rd(16'h0042);
    end
    // R4 illegal codes keep bank 2 and latch the error
    step(16'h8000, 8'h10, 1'b1, 1'b0, 8'h00);
    step(16'h8000, 8'h09, 1'b1, 1'b0, 8'h00);
    rd(16'h0100);
    step(16'h8000, 8'hF9, 1'b1, 1'b0, 8'h00);
    rd(16'h4100);
    step(16'h8000, 8'h08, 1'b1, 1'b0, 8'h00);
    rd(16'h4100);
    // R6 / R7 page windows
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        step(16'h0000, 8'(m << 6 | s << 2), 1'b0, 1'b1, 8'h1D);
        for (int x = 0; x < 2; x++) begin
          step(16'h0000, x ? 8'h08 : 8'h04, 1'b0, 1'b1, 8'h1E);
          rd(16'hC000); rd(16'hDFFF); rd(16'hE001); rd(16'hFFFF);
        end
      end
    end
    // R8 writes elsewhere ignored
    step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h1C);
    step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h1F);
    step(16'h8001, 8'h11, 1'b1, 1'b0, 8'h00);
    step(16'h001D, 8'h00, 1'b1, 1'b0, 8'h1D);
    rd(16'hC345); rd(16'hE345); rd(16'h0345);
    // R1 reset clears error and registers
    do_reset();
    rd(16'h0000); rd(16'hC000); rd(16'hE000);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [7:0] p;
      a = 16'($urandom);
      if ($urandom_range(0, 3) == 0) a = 16'h8000;
      case ($urandom_range(0, 2))
        0: p = 8'h1D;
        1: p = 8'h1E;
        default: p = 8'($urandom);
      endcase
      if (n == 2000) do_reset();
      step(a, 8'($urandom), 1'($urandom), 1'($urandom), p);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule